// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block turns a three-bit processor status code into the timed control strobes of one bus cycle. When the status moves from the passive code to any other code, the block captures that code and runs a fixed four-clock cycle (T1, T2, T3, T4). The cycle produces an address strobe for the external address latch, the direction and enable controls for a bidirectional data transceiver, and one of the active-low commands: memory read, memory write, I/O read, I/O write or interrupt acknowledge.

Each write command has an early copy that goes active one clock before the normal write strobe, so that slow devices get more time. Two live inputs gate the commands. An active-low address enable lets a second bus owner take the bus, and an active-high command enable must be high for any command or for the transceiver enable. A bus-mode select lets the I/O-side commands ignore the address enable when the block drives a dedicated I/O bus.

Top module: `bus_cmd_gen`

## Requirements
- R1: Status codes decode as follows: 000 interrupt acknowledge, 001 I/O read, 010 I/O write, 011 halt, 100 code fetch (memory-read strobe), 101 memory read, 110 memory write, 111 passive. At most one of the five normal commands is active at a time.
- R2: A cycle starts on a clock edge where the sampled status is non-passive and the status sampled at the previous edge was passive. The passive code never starts a cycle. A status held non-passive after T4 does not start a second cycle.
- R3: The address strobe is high for exactly one clock, T1, which is the clock after the start edge. It is low at all other times.
- R4: The memory-read strobe (codes 100 and 101), the I/O-read strobe and the interrupt-acknowledge strobe are low during T2 and T3 only.
- R5: The normal memory-write and I/O-write strobes are low during T3 only. The early write strobes are low during T2 and T3.
- R6: The transceiver direction is low (inbound) from T1 through T4 of read-type cycles (codes 000, 001, 100, 101). It is high at all other times.
- R7: The transceiver enable is high during T2, T3 and T4 of every cycle except halt. It is never high during T1 or when idle.
- R8: A halt cycle pulses the address strobe but drives no command and no transceiver enable.
- R9: With the address enable high (inactive) and bus mode low, every command stays high (inactive).
- R10: With bus mode high, the address enable still blocks the memory commands but does not block the I/O read, I/O write, early I/O write or interrupt-acknowledge strobes.
- R11: With the command enable low, every command stays inactive and the transceiver enable stays low. The address strobe and direction still follow the cycle.
- R12: A synchronous active-high reset returns the sequencer to idle, makes all commands inactive, drives the address strobe and transceiver enable low and the direction high, and treats the last status as passive.
- R13: The command type is captured at the start edge. Status changes during a running cycle change neither the command nor the cycle length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| status_i | input | 3 | Processor status code |
| addr_en_n_i | input | 1 | Address enable, active low |
| cmd_en_i | input | 1 | Command enable, active high |
| io_bus_mode_i | input | 1 | 1: I/O-side commands ignore the address enable |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| mem_wr_early_n_o | output | 1 | Early memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| io_wr_early_n_o | output | 1 | Early I/O write command, active low |
| irq_ack_n_o | output | 1 | Interrupt acknowledge, active low |
| addr_strobe_o | output | 1 | Address latch strobe, active high |
| xcvr_dir_o | output | 1 | Transceiver direction: 1 outbound, 0 inbound |
| xcvr_en_o | output | 1 | Transceiver enable, active high |

## Verification
The status is applied half a clock before the start edge, so T1 appears in the first sample after that edge and T2, T3 and T4 appear at the next three falling edges. A fifth sample confirms a return to idle. The gate inputs act combinationally and are held for the whole cycle, so at every sample the expected strobes follow from the phase and the gate settings, with no added delay. A reset applied during a cycle is checked one edge later.

// File: rtl/bus_cmd_pkg.sv
package bus_cmd_pkg;

    localparam int STATUS_W = 3;
    localparam int PHASE_W  = 3;
    localparam int NUM_CMD  = 7;

    typedef enum logic [STATUS_W-1:0] {
        ST_IACK    = 3'b000,
        ST_IORD    = 3'b001,
        ST_IOWR    = 3'b010,
        ST_HALT    = 3'b011,
        ST_CODE    = 3'b100,
        ST_MRD     = 3'b101,
        ST_MWR     = 3'b110,
        ST_PASSIVE = 3'b111
    } status_e;

    typedef enum logic [PHASE_W-1:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_T4   = 3'd4
    } phase_e;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic io_rd;
        logic io_wr;
        logic iack;
        logic xfer;
    } cmd_kind_t;

    // Lane order inside the command vector; I/O-side lanes sit in the upper bits.
    typedef struct packed {
        logic iack;
        logic io_wr_early;
        logic io_wr;
        logic io_rd;
        logic mem_wr_early;
        logic mem_wr;
        logic mem_rd;
    } cmd_lanes_t;

    localparam logic [NUM_CMD-1:0] IO_LANE_MASK = 7'b111_1000;

    function automatic cmd_kind_t decode_status(input logic [STATUS_W-1:0] code);
        cmd_kind_t k;
        k = '0;
        case (code)
            ST_IACK: begin k.iack   = 1'b1; k.xfer = 1'b1; end
            ST_IORD: begin k.io_rd  = 1'b1; k.xfer = 1'b1; end
            ST_IOWR: begin k.io_wr  = 1'b1; k.xfer = 1'b1; end
            ST_CODE,
            ST_MRD:  begin k.mem_rd = 1'b1; k.xfer = 1'b1; end
            ST_MWR:  begin k.mem_wr = 1'b1; k.xfer = 1'b1; end
            default: k = '0;
        endcase
        return k;
    endfunction

    function automatic logic is_inbound(input cmd_kind_t k);
        return k.mem_rd | k.io_rd | k.iack;
    endfunction

    function automatic phase_e next_phase(input phase_e p);
        case (p)
            PH_T1:   return PH_T2;
            PH_T2:   return PH_T3;
            PH_T3:   return PH_T4;
            default: return PH_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bus_cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [STATUS_W-1:0] status_i,
    output phase_e              phase_o,
    output cmd_kind_t           kind_o
);

    phase_e    phase_q;
    cmd_kind_t kind_q;
    logic      was_passive_q;
    logic      now_active;

    assign now_active = (status_i != ST_PASSIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q       <= PH_IDLE;
            kind_q        <= '0;
            was_passive_q <= 1'b1;
        end else begin
            was_passive_q <= ~now_active;
            if (phase_q == PH_IDLE) begin
                if (was_passive_q && now_active) begin
                    phase_q <= PH_T1;
                    kind_q  <= decode_status(status_i);
                end
            end else begin
                phase_q <= next_phase(phase_q);
            end
        end
    end

    assign phase_o = phase_q;
    assign kind_o  = kind_q;

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
    import bus_cmd_pkg::*;
(
    input  phase_e     phase_i,
    input  cmd_kind_t  kind_i,
    output cmd_lanes_t lanes_o,
    output logic       addr_strobe_o,
    output logic       dir_out_o,
    output logic       xfer_win_o
);

    logic in_t1;
    logic cmd_win;
    logic late_win;
    logic busy;

    assign in_t1    = (phase_i == PH_T1);
    assign cmd_win  = (phase_i == PH_T2) || (phase_i == PH_T3);
    assign late_win = (phase_i == PH_T3);
    assign busy     = (phase_i != PH_IDLE);

    always_comb begin
        lanes_o              = '0;
        lanes_o.mem_rd       = kind_i.mem_rd & cmd_win;
        lanes_o.io_rd        = kind_i.io_rd  & cmd_win;
        lanes_o.iack         = kind_i.iack   & cmd_win;
        lanes_o.mem_wr_early = kind_i.mem_wr & cmd_win;
        lanes_o.io_wr_early  = kind_i.io_wr  & cmd_win;
        lanes_o.mem_wr       = kind_i.mem_wr & late_win;
        lanes_o.io_wr        = kind_i.io_wr  & late_win;
    end

    assign addr_strobe_o = in_t1;
    assign dir_out_o     = ~(busy & is_inbound(kind_i));
    assign xfer_win_o    = kind_i.xfer & (cmd_win | (phase_i == PH_T4));

endmodule

// File: rtl/bus_cmd_gate.sv
module bus_cmd_gate
    import bus_cmd_pkg::*;
(
    input  cmd_lanes_t         lanes_i,
    input  logic               xfer_win_i,
    input  logic               addr_en_n_i,
    input  logic               cmd_en_i,
    input  logic               io_bus_mode_i,
    output logic [NUM_CMD-1:0] cmd_n_o,
    output logic               xcvr_en_o
);

    logic               mem_gate;
    logic               io_gate;
    logic [NUM_CMD-1:0] raw;

    assign mem_gate = cmd_en_i & ~addr_en_n_i;
    assign io_gate  = cmd_en_i & (io_bus_mode_i | ~addr_en_n_i);
    assign raw      = lanes_i;

    for (genvar i = 0; i < NUM_CMD; i++) begin : g_lane
        if (IO_LANE_MASK[i]) begin : g_io
            assign cmd_n_o[i] = ~(raw[i] & io_gate);
        end else begin : g_mem
            assign cmd_n_o[i] = ~(raw[i] & mem_gate);
        end
    end

    assign xcvr_en_o = xfer_win_i & cmd_en_i;

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
    import bus_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] status_i,
    input  logic       addr_en_n_i,
    input  logic       cmd_en_i,
    input  logic       io_bus_mode_i,
    output logic       mem_rd_n_o,
    output logic       mem_wr_n_o,
    output logic       mem_wr_early_n_o,
    output logic       io_rd_n_o,
    output logic       io_wr_n_o,
    output logic       io_wr_early_n_o,
    output logic       irq_ack_n_o,
    output logic       addr_strobe_o,
    output logic       xcvr_dir_o,
    output logic       xcvr_en_o
);

    phase_e             phase;
    cmd_kind_t          kind;
    cmd_lanes_t         lanes;
    logic               xfer_win;
    logic [NUM_CMD-1:0] cmd_n;
    cmd_lanes_t         cmd_n_s;

    bus_cycle_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .status_i (status_i),
        .phase_o  (phase),
        .kind_o   (kind)
    );

    bus_strobe_gen u_strobe (
        .phase_i       (phase),
        .kind_i        (kind),
        .lanes_o       (lanes),
        .addr_strobe_o (addr_strobe_o),
        .dir_out_o     (xcvr_dir_o),
        .xfer_win_o    (xfer_win)
    );

    bus_cmd_gate u_gate (
        .lanes_i       (lanes),
        .xfer_win_i    (xfer_win),
        .addr_en_n_i   (addr_en_n_i),
        .cmd_en_i      (cmd_en_i),
        .io_bus_mode_i (io_bus_mode_i),
        .cmd_n_o       (cmd_n),
        .xcvr_en_o     (xcvr_en_o)
    );

    assign cmd_n_s          = cmd_n;
    assign mem_rd_n_o       = cmd_n_s.mem_rd;
    assign mem_wr_n_o       = cmd_n_s.mem_wr;
    assign mem_wr_early_n_o = cmd_n_s.mem_wr_early;
    assign io_rd_n_o        = cmd_n_s.io_rd;
    assign io_wr_n_o        = cmd_n_s.io_wr;
    assign io_wr_early_n_o  = cmd_n_s.io_wr_early;
    assign irq_ack_n_o      = cmd_n_s.iack;

endmodule

// File: rtl/bus_cmd_gen_chk.sv
module bus_cmd_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] status_i,
    input logic       addr_en_n_i,
    input logic       cmd_en_i,
    input logic       io_bus_mode_i,
    input logic       mem_rd_n_o,
    input logic       mem_wr_n_o,
    input logic       mem_wr_early_n_o,
    input logic       io_rd_n_o,
    input logic       io_wr_n_o,
    input logic       io_wr_early_n_o,
    input logic       irq_ack_n_o,
    input logic       addr_strobe_o,
    input logic       xcvr_dir_o,
    input logic       xcvr_en_o
);

    logic all_idle;
    assign all_idle = mem_rd_n_o && mem_wr_n_o && mem_wr_early_n_o && io_rd_n_o &&
                      io_wr_n_o && io_wr_early_n_o && irq_ack_n_o;

    assert_one_command_R1: assert property (@(posedge clk) disable iff (rst)
        $countones({~mem_rd_n_o, ~mem_wr_n_o, ~io_rd_n_o, ~io_wr_n_o, ~irq_ack_n_o}) <= 1);

    assert_start_from_passive_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_strobe_o) |-> ($past(status_i) != 3'b111));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
        addr_strobe_o |=> !addr_strobe_o);

    assert_mem_write_early_R5: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n_o |-> !mem_wr_early_n_o);

    assert_io_write_early_R5: assert property (@(posedge clk) disable iff (rst)
        !io_wr_n_o |-> !io_wr_early_n_o);

    assert_no_enable_in_t1_R7: assert property (@(posedge clk) disable iff (rst)
        addr_strobe_o |-> !xcvr_en_o);

    assert_addr_enable_block_R9: assert property (@(posedge clk) disable iff (rst)
        (addr_en_n_i && !io_bus_mode_i) |-> all_idle);

    assert_mem_block_iomode_R10: assert property (@(posedge clk) disable iff (rst)
        addr_en_n_i |-> (mem_rd_n_o && mem_wr_n_o && mem_wr_early_n_o));

    assert_cmd_enable_block_R11: assert property (@(posedge clk) disable iff (rst)
        !cmd_en_i |-> (all_idle && !xcvr_en_o));

    assert_reset_state_R12: assert property (@(posedge clk)
        rst |=> (all_idle && !addr_strobe_o && !xcvr_en_o && xcvr_dir_o));

endmodule

bind bus_cmd_gen bus_cmd_gen_chk u_chk (.*);

// File: tb/bus_cmd_gen_tb.sv
module bus_cmd_gen_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] status_i = 3'b111;
    logic       addr_en_n_i = 1'b0;
    logic       cmd_en_i = 1'b1;
    logic       io_bus_mode_i = 1'b0;
    logic       mem_rd_n_o, mem_wr_n_o, mem_wr_early_n_o, io_rd_n_o, io_wr_n_o;
    logic       io_wr_early_n_o, irq_ack_n_o, addr_strobe_o, xcvr_dir_o, xcvr_en_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    bus_cmd_gen u_dut (
        .clk              (clk),
        .rst              (rst),
        .status_i         (status_i),
        .addr_en_n_i      (addr_en_n_i),
        .cmd_en_i         (cmd_en_i),
        .io_bus_mode_i    (io_bus_mode_i),
        .mem_rd_n_o       (mem_rd_n_o),
        .mem_wr_n_o       (mem_wr_n_o),
        .mem_wr_early_n_o (mem_wr_early_n_o),
        .io_rd_n_o        (io_rd_n_o),
        .io_wr_n_o        (io_wr_n_o),
        .io_wr_early_n_o  (io_wr_early_n_o),
        .irq_ack_n_o      (irq_ack_n_o),
        .addr_strobe_o    (addr_strobe_o),
        .xcvr_dir_o       (xcvr_dir_o),
        .xcvr_en_o        (xcvr_en_o)
    );

    // Bit order: 9 strobe, 8 dir, 7 en, 6 iack_n, 5 io_wr_early_n, 4 io_wr_n,
    // 3 io_rd_n, 2 mem_wr_early_n, 1 mem_wr_n, 0 mem_rd_n
    function automatic logic [9:0] observe();
        return {addr_strobe_o, xcvr_dir_o, xcvr_en_o, irq_ack_n_o, io_wr_early_n_o,
                io_wr_n_o, io_rd_n_o, mem_wr_early_n_o, mem_wr_n_o, mem_rd_n_o};
    endfunction

    function automatic logic [9:0] expect_out(input logic [2:0] code, input int ph,
                                              input logic aen_n, input logic cen,
                                              input logic iob);
        logic g_mem, g_io, rd, win, late;
        logic [9:0] e;
        int p;
        p     = (code == 3'd7) ? 0 : ph;
        g_mem = cen & ~aen_n;
        g_io  = cen & (iob | ~aen_n);
        rd    = (code == 3'd0) || (code == 3'd1) || (code == 3'd4) || (code == 3'd5);
        win   = (p == 2) || (p == 3);
        late  = (p == 3);
        e       = 10'b01_0_1111111;
        e[9]    = (p == 1);
        e[8]    = !((p != 0) && rd);
        e[7]    = cen && (p >= 2) && (code != 3'd3);
        e[6]    = !(win  && code == 3'd0 && g_io);
        e[5]    = !(win  && code == 3'd2 && g_io);
        e[4]    = !(late && code == 3'd2 && g_io);
        e[3]    = !(win  && code == 3'd1 && g_io);
        e[2]    = !(win  && code == 3'd6 && g_mem);
        e[1]    = !(late && code == 3'd6 && g_mem);
        e[0]    = !(win  && (code == 3'd4 || code == 3'd5) && g_mem);
        return e;
    endfunction

    function automatic string bit_tag(input int b);
        case (b)
            9: return "R3";
            8: return "R6";
            7: return "R7";
            6: return "R1";
            3, 0: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic compare(input string ctx, input logic [9:0] act, input logic [9:0] exp,
                           input int ph);
        for (int b = 0; b < 10; b++) begin
            checks++;
            if (act[b] !== exp[b]) begin
                errors++;
                $display("FAIL %s %s phase %0d bit %0d: actual %b expected %b",
                         bit_tag(b), ctx, ph, b, act[b], exp[b]);
            end
        end
    endtask

    task automatic run_cycle(input logic [2:0] code, input logic aen_n, input logic cen,
                             input logic iob, input logic scramble);
        string ctx;
        if (code == 3'd7)       ctx = "R2";
        else if (scramble)      ctx = "R13";
        else if (code == 3'd3)  ctx = "R8";
        else if (!cen)          ctx = "R11";
        else if (aen_n && iob)  ctx = "R10";
        else if (aen_n)         ctx = "R9";
        else                    ctx = "R1";
        @(negedge clk);
        status_i      = 3'b111;
        addr_en_n_i   = aen_n;
        cmd_en_i      = cen;
        io_bus_mode_i = iob;
        @(negedge clk);
        @(negedge clk);
        status_i = code;
        for (int ph = 1; ph <= 5; ph++) begin
            @(negedge clk);
            compare(ctx, observe(), expect_out(code, (ph == 5) ? 0 : ph, aen_n, cen, iob), ph);
            if (scramble && ph == 2) status_i = code ^ 3'b011;
        end
    endtask

    initial begin : watchdog
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R12: state after reset
        compare("R12", observe(), expect_out(3'd7, 0, 1'b0, 1'b1, 1'b0), 0);
        rst = 1'b0;

        for (int c = 0; c < 8; c++)
            for (int v = 0; v < 16; v++)
                if (!(v[3] && c == 7))
                    run_cycle(c[2:0], v[0], v[1], v[2], v[3]);

        // R12: reset in the middle of a memory read
        @(negedge clk);
        addr_en_n_i = 1'b0; cmd_en_i = 1'b1; io_bus_mode_i = 1'b0; status_i = 3'b111;
        @(negedge clk);
        @(negedge clk);
        status_i = 3'd5;
        @(negedge clk);
        @(negedge clk);
        compare("R12", observe(), expect_out(3'd5, 2, 1'b0, 1'b1, 1'b0), 2);
        rst = 1'b1;
        status_i = 3'b111;
        @(negedge clk);
        compare("R12", observe(), expect_out(3'd7, 0, 1'b0, 1'b1, 1'b0), 0);
        rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            compare("R12", observe(), expect_out(3'd7, 0, 1'b0, 1'b1, 1'b0), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule